// File: doc/BRIEF.md
# DMA Write Merge Buffer

This block sits in the data switch between an I/O bus and cached main memory and assembles the memory write for each DMA write. An accepted DMA write carries one block of data, a byte-enable mask and a block address. On the same cycle, the block raises a fetch strobe that names the buffer set and the address. The surrounding logic uses that strobe to start a memory read and a cache flush of the target block at the same time. The memory read and the flush return on their own response ports, each tagged with the set number, in any order and in any cycle.

A buffer set is ready when its I/O data, its old memory contents and its flush result are all present. The set then offers one merged block on the memory write port. For each byte, the DMA data is used when its byte enable is set. Otherwise a dirty flushed line supplies the byte, and otherwise the old memory data is used. A flush that finds no line, or only a clean one, leaves the flush buffer marked empty.

There are two buffer sets, so two DMA writes can be in progress at once. Sets are handed out in turn, and memory writes leave in the order the DMA writes were accepted.

Top module: `dmw_merge_top`

## Requirements
- R1: Out of reset `dma_ready` is 1 and `mwr_valid` and `fetch_valid` are 0. No memory write is offered while no DMA write is pending.
- R2: A DMA write is accepted in a cycle where `dma_valid` and `dma_ready` are both 1. In that same cycle `fetch_valid` is 1, `fetch_addr` equals `dma_addr`, and `fetch_set` names the set being filled. `fetch_valid` is 0 in every other cycle.
- R3: Set numbers are 0 and 1. The first write after reset goes to set 0, and each later write goes to the other set from the one before it.
- R4: A set offers its memory write only after its memory response and its flush response have both been captured. The two responses may arrive together or in either order.
- R5: In the merged block, byte b (bits 8b+7:8b) is the DMA byte when `dma_be[b]` is 1. Otherwise it is the flushed byte if the flush reported `flush_dirty` = 1, and otherwise the memory byte.
- R6: A flush response with `flush_dirty` = 0 has no effect on the merged block. Every byte without an enable then comes from memory.
- R7: When both sets are busy, `dma_ready` is 0 and no write is accepted. `dma_ready` returns to 1 once a memory write completes.
- R8: Memory writes complete in acceptance order, even when the younger set has all its loads before the older set does.
- R9: While `mwr_valid` is 1 and `mwr_ready` is 0, `mwr_valid`, `mwr_addr` and `mwr_data` stay unchanged.
- R10: `mwr_addr` equals the `dma_addr` of the DMA write being retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_valid | input | 1 | DMA write offered |
| dma_ready | output | 1 | DMA write can be accepted |
| dma_addr | input | ADDR_W | Block address of the DMA write |
| dma_data | input | BLK_BYTES*8 | DMA write data |
| dma_be | input | BLK_BYTES | Byte enables of the DMA write |
| fetch_valid | output | 1 | Start memory read and cache flush for a new write |
| fetch_set | output | 1 | Set that the fetch results belong to |
| fetch_addr | output | ADDR_W | Block to read and flush |
| mrsp_valid | input | 1 | Memory read data returned |
| mrsp_set | input | 1 | Set of the memory read data |
| mrsp_data | input | BLK_BYTES*8 | Old memory contents of the block |
| flush_valid | input | 1 | Cache flush result returned |
| flush_set | input | 1 | Set of the flush result |
| flush_dirty | input | 1 | Flush returned a dirty line |
| flush_data | input | BLK_BYTES*8 | Flushed line contents |
| mwr_valid | output | 1 | Merged block offered to memory |
| mwr_ready | input | 1 | Memory takes the merged block |
| mwr_addr | output | ADDR_W | Address of the merged block |
| mwr_data | output | BLK_BYTES*8 | Merged block |

## Verification
The bench builds the block with BLK_BYTES = 8 and ADDR_W = 16. A block is then a single 64-bit word, so every byte-enable pattern, including all clear and all set, can be reached and checked against a reference merge. With this narrow block the reference model stays small, while per-byte priority, response ordering across both sets and the full-stall case are all still exercised.

// File: rtl/dmw_pkg.sv
// Package: shared types for the DMA write merge buffer.
// Assumes: exactly two buffer sets, addressed by a one-bit index.
package dmw_pkg;
    localparam int NUM_SETS = 2;

    typedef logic set_idx_t;

    typedef enum logic {
        SET_FREE = 1'b0,
        SET_LOAD = 1'b1
    } set_state_e;
endpackage

// File: rtl/dmw_order.sv
// Module: allocation and retirement pointers.
// Gives new writes to the sets in turn and retires them in the same turn,
// which keeps memory writes in acceptance order.
// Assumes: accept and retire pulse for one cycle per transfer.
module dmw_order
    import dmw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     accept,
    input  logic     retire,
    output set_idx_t alloc_ptr,
    output set_idx_t drain_ptr
);
    // Advance the fill pointer on each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            alloc_ptr <= 1'b0;
        else if (accept)
            alloc_ptr <= ~alloc_ptr;
    end

    // Advance the retire pointer on each completed memory write
    always_ff @(posedge clk) begin
        if (!rst_n)
            drain_ptr <= 1'b0;
        else if (retire)
            drain_ptr <= ~drain_ptr;
    end
endmodule

// File: rtl/dmw_buf_set.sv
// Module: one buffer set. It holds the DMA data, byte enables and address,
// the old memory block and the flushed line, plus a load flag for each source.
// Assumes: responses arrive only for a set that is loading, and at most once each.
module dmw_buf_set
    import dmw_pkg::*;
#(
    parameter int BLK_BYTES = 32,
    parameter int ADDR_W    = 32,
    localparam int BLK_BITS = BLK_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc,
    input  logic                release_set,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [BLK_BITS-1:0] in_data,
    input  logic [BLK_BYTES-1:0] in_be,
    input  logic                mem_hit,
    input  logic [BLK_BITS-1:0] mem_data_in,
    input  logic                fl_hit,
    input  logic                fl_dirty_in,
    input  logic [BLK_BITS-1:0] fl_data_in,
    output logic                busy,
    output logic                loaded,
    output logic [ADDR_W-1:0]   q_addr,
    output logic [BLK_BITS-1:0] q_io,
    output logic [BLK_BYTES-1:0] q_be,
    output logic [BLK_BITS-1:0] q_mem,
    output logic [BLK_BITS-1:0] q_fl,
    output logic                q_fl_use
);
    set_state_e state;
    logic       mem_done;
    logic       fl_done;

    // Control: set lifecycle, load flags and flush-valid marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SET_FREE;
            mem_done <= 1'b0;
            fl_done  <= 1'b0;
            q_fl_use <= 1'b0;
        end else if (release_set) begin
            state    <= SET_FREE;
            mem_done <= 1'b0;
            fl_done  <= 1'b0;
            q_fl_use <= 1'b0;
        end else if (alloc) begin
            state    <= SET_LOAD;
            mem_done <= 1'b0;
            fl_done  <= 1'b0;
            q_fl_use <= 1'b0;
        end else if (state == SET_LOAD) begin
            if (mem_hit)
                mem_done <= 1'b1;
            if (fl_hit) begin
                fl_done  <= 1'b1;
                q_fl_use <= fl_dirty_in;
            end
        end
    end

    // Data: capture each source as it arrives (no reset needed on storage)
    always_ff @(posedge clk) begin
        if (alloc && state == SET_FREE) begin
            q_addr <= in_addr;
            q_io   <= in_data;
            q_be   <= in_be;
        end
        if (mem_hit && state == SET_LOAD)
            q_mem <= mem_data_in;
        if (fl_hit && state == SET_LOAD)
            q_fl <= fl_data_in;
    end

    assign busy   = (state == SET_LOAD);
    assign loaded = busy && mem_done && fl_done;
endmodule

// File: rtl/dmw_merge.sv
// Module: per-byte three-way merge.
// DMA byte when enabled, else dirty flushed byte, else memory byte.
// Assumes: fl_use is 0 when the flush found no line or a clean one.
module dmw_merge #(
    parameter int BLK_BYTES = 32,
    localparam int BLK_BITS = BLK_BYTES * 8
) (
    input  logic [BLK_BITS-1:0]  io_data,
    input  logic [BLK_BYTES-1:0] io_be,
    input  logic [BLK_BITS-1:0]  mem_data,
    input  logic [BLK_BITS-1:0]  fl_data,
    input  logic                 fl_use,
    output logic [BLK_BITS-1:0]  out_data
);
    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
        // Pick the source of one byte by priority
        assign out_data[b*8 +: 8] = io_be[b] ? io_data[b*8 +: 8] :
                                    fl_use   ? fl_data[b*8 +: 8] :
                                               mem_data[b*8 +: 8];
    end
endmodule

// File: rtl/dmw_merge_top.sv
// Module: DMA write merge buffer top.
// Accepts DMA writes into two buffer sets in turn, starts the memory read
// and cache flush of each write, merges the three sources when all are in,
// and retires the merged blocks to memory in acceptance order.
// Assumes: mrsp/flush responses are tagged with the set named by fetch_set.
module dmw_merge_top
    import dmw_pkg::*;
#(
    parameter int BLK_BYTES = 32,
    parameter int ADDR_W    = 32,
    localparam int BLK_BITS = BLK_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dma_valid,
    output logic                 dma_ready,
    input  logic [ADDR_W-1:0]    dma_addr,
    input  logic [BLK_BITS-1:0]  dma_data,
    input  logic [BLK_BYTES-1:0] dma_be,
    output logic                 fetch_valid,
    output logic                 fetch_set,
    output logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 mrsp_valid,
    input  logic                 mrsp_set,
    input  logic [BLK_BITS-1:0]  mrsp_data,
    input  logic                 flush_valid,
    input  logic                 flush_set,
    input  logic                 flush_dirty,
    input  logic [BLK_BITS-1:0]  flush_data,
    output logic                 mwr_valid,
    input  logic                 mwr_ready,
    output logic [ADDR_W-1:0]    mwr_addr,
    output logic [BLK_BITS-1:0]  mwr_data
);
    set_idx_t              alloc_ptr;
    set_idx_t              drain_ptr;
    logic                  accept;
    logic                  retire;
    logic [NUM_SETS-1:0]   set_busy;
    logic [NUM_SETS-1:0]   set_loaded;
    logic [ADDR_W-1:0]     s_addr [NUM_SETS];
    logic [BLK_BITS-1:0]   s_io   [NUM_SETS];
    logic [BLK_BYTES-1:0]  s_be   [NUM_SETS];
    logic [BLK_BITS-1:0]   s_mem  [NUM_SETS];
    logic [BLK_BITS-1:0]   s_fl   [NUM_SETS];
    logic [NUM_SETS-1:0]   s_fl_use;

    assign dma_ready   = !set_busy[alloc_ptr];
    assign accept      = dma_valid && dma_ready;
    assign fetch_valid = accept;
    assign fetch_set   = alloc_ptr;
    assign fetch_addr  = dma_addr;
    assign mwr_valid   = set_loaded[drain_ptr];
    assign retire      = mwr_valid && mwr_ready;

    dmw_order i_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .retire    (retire),
        .alloc_ptr (alloc_ptr),
        .drain_ptr (drain_ptr)
    );

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        dmw_buf_set #(
            .BLK_BYTES (BLK_BYTES),
            .ADDR_W    (ADDR_W)
        ) i_set (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (accept && (alloc_ptr == set_idx_t'(g))),
            .release_set (retire && (drain_ptr == set_idx_t'(g))),
            .in_addr     (dma_addr),
            .in_data     (dma_data),
            .in_be       (dma_be),
            .mem_hit     (mrsp_valid && (mrsp_set == set_idx_t'(g))),
            .mem_data_in (mrsp_data),
            .fl_hit      (flush_valid && (flush_set == set_idx_t'(g))),
            .fl_dirty_in (flush_dirty),
            .fl_data_in  (flush_data),
            .busy        (set_busy[g]),
            .loaded      (set_loaded[g]),
            .q_addr      (s_addr[g]),
            .q_io        (s_io[g]),
            .q_be        (s_be[g]),
            .q_mem       (s_mem[g]),
            .q_fl        (s_fl[g]),
            .q_fl_use    (s_fl_use[g])
        );
    end

    assign mwr_addr = s_addr[drain_ptr];

    dmw_merge #(
        .BLK_BYTES (BLK_BYTES)
    ) i_merge (
        .io_data  (s_io[drain_ptr]),
        .io_be    (s_be[drain_ptr]),
        .mem_data (s_mem[drain_ptr]),
        .fl_data  (s_fl[drain_ptr]),
        .fl_use   (s_fl_use[drain_ptr]),
        .out_data (mwr_data)
    );
endmodule

// File: rtl/dmw_checker.sv
// Module: protocol checker for dmw_merge_top, attached by bind.
// Keeps its own count of pending writes, its own retire order and its own
// per-set response flags, and checks the top-level handshakes against them.
module dmw_checker #(
    parameter int ADDR_W   = 32,
    parameter int BLK_BITS = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dma_ready,
    input logic                fetch_valid,
    input logic                fetch_set,
    input logic                mrsp_valid,
    input logic                mrsp_set,
    input logic                flush_valid,
    input logic                flush_set,
    input logic                mwr_valid,
    input logic                mwr_ready,
    input logic [ADDR_W-1:0]   mwr_addr,
    input logic [BLK_BITS-1:0] mwr_data,
    input logic [1:0]          set_busy
);
    logic       seen;
    logic       last_set;
    logic       dr;
    logic [1:0] pend;
    logic [1:0] got_mem;
    logic [1:0] got_fl;
    logic       wr_done;

    assign wr_done = mwr_valid && mwr_ready;

    // Track last allocated set, retire order, pending count and responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_set <= 1'b0;
            dr       <= 1'b0;
            pend     <= 2'd0;
            got_mem  <= 2'b00;
            got_fl   <= 2'b00;
        end else begin
            if (fetch_valid) begin
                seen     <= 1'b1;
                last_set <= fetch_set;
            end
            if (wr_done)
                dr <= ~dr;
            pend <= pend + {1'b0, fetch_valid} - {1'b0, wr_done};
            for (int s = 0; s < 2; s++) begin
                if (wr_done && dr == s[0]) begin
                    got_mem[s] <= 1'b0;
                    got_fl[s]  <= 1'b0;
                end else begin
                    if (mrsp_valid && mrsp_set == s[0])
                        got_mem[s] <= 1'b1;
                    if (flush_valid && flush_set == s[0])
                        got_fl[s] <= 1'b1;
                end
            end
        end
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == 2'd0) |-> !mwr_valid);                                       // R1
    AST_ALT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && seen) |-> (fetch_set != last_set));                   // R3
    AST_LOADS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_valid |-> (got_mem[dr] && got_fl[dr]));                           // R4
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (set_busy == 2'b11) |-> !dma_ready);                                  // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (pend < 2'd2));                                       // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_valid && !mwr_ready) |=>
            (mwr_valid && $stable(mwr_addr) && $stable(mwr_data)));           // R9
endmodule

bind dmw_merge_top dmw_checker #(
    .ADDR_W   (ADDR_W),
    .BLK_BITS (BLK_BITS)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_ready   (dma_ready),
    .fetch_valid (fetch_valid),
    .fetch_set   (fetch_set),
    .mrsp_valid  (mrsp_valid),
    .mrsp_set    (mrsp_set),
    .flush_valid (flush_valid),
    .flush_set   (flush_set),
    .mwr_valid   (mwr_valid),
    .mwr_ready   (mwr_ready),
    .mwr_addr    (mwr_addr),
    .mwr_data    (mwr_data),
    .set_busy    (set_busy)
);

// File: tb/test_dmw_merge_top.sv
// Bench: directed scenarios, one task each, with a reference merge model.
module test_dmw_merge_top;
    localparam int BB = 8;
    localparam int AW = 16;
    localparam int DW = BB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dma_valid = 1'b0;
    logic          dma_ready;
    logic [AW-1:0] dma_addr = '0;
    logic [DW-1:0] dma_data = '0;
    logic [BB-1:0] dma_be = '0;
    logic          fetch_valid;
    logic          fetch_set;
    logic [AW-1:0] fetch_addr;
    logic          mrsp_valid = 1'b0;
    logic          mrsp_set = 1'b0;
    logic [DW-1:0] mrsp_data = '0;
    logic          flush_valid = 1'b0;
    logic          flush_set = 1'b0;
    logic          flush_dirty = 1'b0;
    logic [DW-1:0] flush_data = '0;
    logic          mwr_valid;
    logic          mwr_ready = 1'b0;
    logic [AW-1:0] mwr_addr;
    logic [DW-1:0] mwr_data;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dmw_merge_top #(.BLK_BYTES(BB), .ADDR_W(AW)) i_dmw_merge_top (
        .clk(clk), .rst_n(rst_n),
        .dma_valid(dma_valid), .dma_ready(dma_ready),
        .dma_addr(dma_addr), .dma_data(dma_data), .dma_be(dma_be),
        .fetch_valid(fetch_valid), .fetch_set(fetch_set), .fetch_addr(fetch_addr),
        .mrsp_valid(mrsp_valid), .mrsp_set(mrsp_set), .mrsp_data(mrsp_data),
        .flush_valid(flush_valid), .flush_set(flush_set),
        .flush_dirty(flush_dirty), .flush_data(flush_data),
        .mwr_valid(mwr_valid), .mwr_ready(mwr_ready),
        .mwr_addr(mwr_addr), .mwr_data(mwr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_merge(input logic [BB-1:0] be, input logic [DW-1:0] io,
                                                input logic [DW-1:0] mem, input bit dirty,
                                                input logic [DW-1:0] fl);
        logic [DW-1:0] r;
        for (int b = 0; b < BB; b++)
            r[b*8 +: 8] = be[b] ? io[b*8 +: 8] : (dirty ? fl[b*8 +: 8] : mem[b*8 +: 8]);
        return r;
    endfunction

    // Offer one DMA write, wait for acceptance, check the fetch strobe
    task automatic do_accept(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [BB-1:0] be, output logic s);
        @(negedge clk);
        dma_valid = 1'b1; dma_addr = a; dma_data = d; dma_be = be;
        #1;
        while (!dma_ready) begin
            @(negedge clk);
            #1;
        end
        s = fetch_set;
        chk(fetch_valid == 1'b1, "R2 fetch_valid", 64'(fetch_valid), 64'd1);
        chk(fetch_addr == a, "R2 fetch_addr", 64'(fetch_addr), 64'(a));
        @(negedge clk);
        dma_valid = 1'b0;
    endtask

    task automatic send_mem(input logic s, input logic [DW-1:0] d);
        @(negedge clk);
        mrsp_valid = 1'b1; mrsp_set = s; mrsp_data = d;
        @(negedge clk);
        mrsp_valid = 1'b0;
    endtask

    task automatic send_fl(input logic s, input bit dirty, input logic [DW-1:0] d);
        @(negedge clk);
        flush_valid = 1'b1; flush_set = s; flush_dirty = dirty; flush_data = d;
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    // order 0: both together, 1: memory first, 2: flush first
    task automatic send_loads(input logic s, input logic [DW-1:0] md, input bit dirty,
                              input logic [DW-1:0] fd, input int order);
        if (order == 0) begin
            @(negedge clk);
            mrsp_valid = 1'b1; mrsp_set = s; mrsp_data = md;
            flush_valid = 1'b1; flush_set = s; flush_dirty = dirty; flush_data = fd;
            @(negedge clk);
            mrsp_valid = 1'b0; flush_valid = 1'b0;
        end else if (order == 1) begin
            send_mem(s, md);
            send_fl(s, dirty, fd);
        end else begin
            send_fl(s, dirty, fd);
            send_mem(s, md);
        end
    endtask

    // Wait for a memory write, compare it, then take it
    task automatic take_write(input logic [AW-1:0] ea, input logic [DW-1:0] ed, input string tag);
        int guard = 0;
        @(negedge clk);
        #1;
        while (!mwr_valid && guard < 50) begin
            @(negedge clk);
            #1;
            guard++;
        end
        chk(mwr_valid == 1'b1, {tag, " R4 write offered"}, 64'(mwr_valid), 64'd1);
        chk(mwr_addr == ea, {tag, " R10 address"}, 64'(mwr_addr), 64'(ea));
        chk(mwr_data == ed, {tag, " R5 data"}, mwr_data, ed);
        mwr_ready = 1'b1;
        @(negedge clk);
        mwr_ready = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(dma_ready == 1'b1, "R1 dma_ready", 64'(dma_ready), 64'd1);
        chk(mwr_valid == 1'b0, "R1 mwr_valid", 64'(mwr_valid), 64'd0);
        chk(fetch_valid == 1'b0, "R1 fetch_valid", 64'(fetch_valid), 64'd0);
    endtask

    task automatic t_basic();
        logic s;
        logic [DW-1:0] io = 64'h1111_2222_3333_4444;
        logic [DW-1:0] md = 64'hAAAA_BBBB_CCCC_DDDD;
        logic [DW-1:0] fd = 64'h5566_7788_99AA_BBCC;
        do_accept(16'h0100, io, 8'b1010_0101, s);
        chk(s == 1'b0, "R3 first set", 64'(s), 64'd0);
        #1;
        chk(fetch_valid == 1'b0, "R2 single pulse", 64'(fetch_valid), 64'd0);
        send_mem(s, md);
        #1;
        chk(mwr_valid == 1'b0, "R4 memory only", 64'(mwr_valid), 64'd0);
        send_fl(s, 1'b1, fd);
        #1;
        chk(mwr_valid == 1'b1, "R4 all loaded", 64'(mwr_valid), 64'd1);
        repeat (3) @(negedge clk);
        #1;
        chk(mwr_valid == 1'b1, "R9 valid held", 64'(mwr_valid), 64'd1);
        chk(mwr_data == ref_merge(8'b1010_0101, io, md, 1'b1, fd), "R9 data held",
            mwr_data, ref_merge(8'b1010_0101, io, md, 1'b1, fd));
        take_write(16'h0100, ref_merge(8'b1010_0101, io, md, 1'b1, fd), "basic");
        #1;
        chk(mwr_valid == 1'b0, "R1 idle after retire", 64'(mwr_valid), 64'd0);
    endtask

    task automatic t_clean();
        logic s;
        logic [DW-1:0] io = 64'hFEDC_BA98_7654_3210;
        logic [DW-1:0] md = 64'h0F0F_0F0F_0F0F_0F0F;
        logic [DW-1:0] fd = 64'hDEAD_BEEF_DEAD_BEEF;
        do_accept(16'h0240, io, 8'b0000_0011, s);
        chk(s == 1'b1, "R3 alternate set", 64'(s), 64'd1);
        send_loads(s, md, 1'b0, fd, 2);
        take_write(16'h0240, ref_merge(8'b0000_0011, io, md, 1'b0, fd), "R6 clean flush");
    endtask

    task automatic t_order();
        logic sa;
        logic sb;
        logic [DW-1:0] ioa = 64'h0102_0304_0506_0708;
        logic [DW-1:0] iob = 64'h1112_1314_1516_1718;
        logic [DW-1:0] mda = 64'h2122_2324_2526_2728;
        logic [DW-1:0] mdb = 64'h3132_3334_3536_3738;
        logic [DW-1:0] fda = 64'h4142_4344_4546_4748;
        logic [DW-1:0] fdb = 64'h5152_5354_5556_5758;
        do_accept(16'h1000, ioa, 8'h0F, sa);
        do_accept(16'h2000, iob, 8'hF0, sb);
        chk(sa != sb, "R3 distinct sets", 64'(sb), 64'(~sa));
        @(negedge clk);
        dma_valid = 1'b1; dma_addr = 16'h3000;
        #1;
        chk(dma_ready == 1'b0, "R7 stall when full", 64'(dma_ready), 64'd0);
        chk(fetch_valid == 1'b0, "R7 no accept when full", 64'(fetch_valid), 64'd0);
        @(negedge clk);
        dma_valid = 1'b0;
        send_loads(sb, mdb, 1'b1, fdb, 0);
        #1;
        chk(mwr_valid == 1'b0, "R8 younger waits", 64'(mwr_valid), 64'd0);
        send_loads(sa, mda, 1'b1, fda, 1);
        take_write(16'h1000, ref_merge(8'h0F, ioa, mda, 1'b1, fda), "R8 older first");
        #1;
        chk(dma_ready == 1'b1, "R7 ready after retire", 64'(dma_ready), 64'd1);
        take_write(16'h2000, ref_merge(8'hF0, iob, mdb, 1'b1, fdb), "R8 younger second");
    endtask

    task automatic t_random();
        for (int i = 0; i < 16; i++) begin
            logic s;
            logic [DW-1:0] io = {$urandom, $urandom};
            logic [DW-1:0] md = {$urandom, $urandom};
            logic [DW-1:0] fd = {$urandom, $urandom};
            logic [BB-1:0] be = (i == 0) ? '0 : (i == 1) ? '1 : BB'($urandom);
            bit dirty = (i < 2) ? 1'b1 : 1'($urandom);
            logic [AW-1:0] a = AW'($urandom);
            do_accept(a, io, be, s);
            send_loads(s, md, dirty, fd, i % 3);
            take_write(a, ref_merge(be, io, md, dirty, fd), "R5 random merge");
        end
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_clean();
        t_order();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule